// File: doc/BRIEF.md
# Per-Phase Overcurrent Monitor

This block watches the half-cycle RMS current of three line phases and flags an overcurrent condition. Each phase delivers an RMS word together with a one-cycle valid strobe. When a monitored phase reports a value strictly above one shared programmable limit, the block does four things: it raises a sticky overcurrent flag, marks that phase in a per-phase indicator field, stores the offending value in that phase's capture register, and drives the interrupt output.

Software configures the block through a simple register port. The port has a write strobe with a write address and data, and a separate read address with combinational read data. Software sets the limit and the monitoring mask, reads the status and the captured values, and acknowledges an event by writing 1 to the flag bit. The RMS computation happens upstream and is not part of this block.

Top module: `phase_overcurrent_monitor`

## Requirements
- R1: After reset the limit register reads all ones, the mask reads 0, the status reads 0, every capture register reads 0 and `oc_irq` is low.
- R2: A phase trips only in a cycle where its valid strobe is high, its mask bit is set and its sample is strictly greater than the limit. A sample equal to the limit, or a sample with valid low, does not trip.
- R3: A trip sets the status flag (status bit 0) and `oc_irq` from the next cycle on. Both stay set until software clears them.
- R4: A trip on phase p sets status bit 4+p from the next cycle on.
- R5: A trip on a phase whose indicator bit is clear loads that sample into the phase's capture register.
- R6: While a phase's indicator bit is set, a further trip on that phase replaces its capture value only if the new sample is larger.
- R7: A phase whose mask bit is clear never sets its indicator bit, never changes its capture register and never sets the flag.
- R8: Writing a word with bit 0 set to the status address clears the flag, `oc_irq` and all indicator bits in the next cycle. Capture registers keep their values. Writing 0 to bit 0 has no effect.
- R9: If a trip and a clearing write fall in the same cycle, the trip wins. The flag stays set, and so does the tripping phase's indicator bit.
- R10: Register map: address 0 is the limit (read/write, full width). Address 1 is the mask (read/write in bits [2:0], upper bits read 0). Address 2 is the status (flag in bit 0, indicators in bits [6:4]). Address 3+p is the capture register of phase p. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_rms | input | NUM_PH*DW | Per-phase RMS samples, phase p in bits [p*DW +: DW] |
| cur_vld | input | NUM_PH | Per-phase sample valid strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | DW | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | DW | Register read data (combinational) |
| oc_irq | output | 1 | Overcurrent interrupt, high while the flag is set |

## Verification
Every stored result is due exactly one cycle after the rising edge that samples its stimulus. This covers the flag, the interrupt, the indicator bits, the capture values and the register writes. Read data follows the read address within the same cycle. The bench updates a behavioural model at each rising edge from the same input values the design sees. At the following falling edge it compares `oc_irq` and `reg_rdata` against that model, and it drives new stimulus one nanosecond later. As a result, each check lands in the cycle where the result first becomes due.

// File: rtl/ocm_pkg.sv
// Shared constants for the overcurrent monitor: register addresses
// and status-word bit positions.
package ocm_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_LIMIT    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK     = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_BASE = 3'd3;
    localparam int FLAG_BIT = 0;
    localparam int IND_LSB  = 4;
endpackage

// File: rtl/ocm_phase_slice.sv
// One phase of the overcurrent monitor. Compares the phase sample
// against the shared limit, keeps the phase indicator bit and the
// capture register. Assumes in_rms is meaningful only while in_vld.
module ocm_phase_slice #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_rms,
    input  logic          in_vld,
    input  logic          mon_en,
    input  logic [DW-1:0] limit,
    input  logic          ind_clr,
    output logic          trip,
    output logic          ind,
    output logic [DW-1:0] cap
);
    logic take;

    // Strict comparison, gated by valid and the phase enable.
    assign trip = in_vld && mon_en && (in_rms > limit);
    // Load when the phase is fresh, or when the new value is larger.
    assign take = trip && (!ind || (in_rms > cap));

    // Indicator bit: a trip sets it and outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ind <= 1'b0;
        else if (trip)    ind <= 1'b1;
        else if (ind_clr) ind <= 1'b0;
    end

    // Capture register holding the value that tripped the phase.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap <= '0;
        else if (take) cap <= in_rms;
    end

    // R4
    ind_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> ind);
    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> $stable(cap));
    // R5
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !ind) |=> (cap == $past(in_rms)));
    // R6
    cap_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind |=> (cap >= $past(cap)));
endmodule

// File: rtl/ocm_regs.sv
// Register file of the overcurrent monitor. Holds the limit, the
// enable mask and the sticky flag, and builds the read mux. Assumes
// the phase slices supply the indicator bits and capture values.
module ocm_regs
    import ocm_pkg::*;
#(
    parameter int NUM_PH = 3,
    parameter int DW     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [ADDR_W-1:0]    raddr,
    output logic [DW-1:0]        rdata,
    input  logic                 any_trip,
    input  logic [NUM_PH-1:0]    ind,
    input  logic [NUM_PH*DW-1:0] caps,
    output logic [DW-1:0]        limit,
    output logic [NUM_PH-1:0]    mask,
    output logic                 ind_clr,
    output logic                 flag
);
    // Write-one-to-clear decode for the status flag.
    assign ind_clr = wr && (waddr == A_STATUS) && wdata[FLAG_BIT];

    // Limit register; resets high so nothing can trip.
    always_ff @(posedge clk) begin
        if (!rst_n)                        limit <= '1;
        else if (wr && waddr == A_LIMIT)   limit <= wdata;
    end

    // Per-phase monitoring mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask <= '0;
        else if (wr && waddr == A_MASK)    mask <= wdata[NUM_PH-1:0];
    end

    // Sticky overcurrent flag; a new trip outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (any_trip) flag <= 1'b1;
        else if (ind_clr)  flag <= 1'b0;
    end

    // Combinational read mux over the register map.
    always_comb begin
        rdata = '0;
        case (raddr)
            A_LIMIT:  rdata = limit;
            A_MASK:   rdata[NUM_PH-1:0] = mask;
            A_STATUS: begin
                rdata[FLAG_BIT]         = flag;
                rdata[IND_LSB +: NUM_PH] = ind;
            end
            default: begin
                for (int p = 0; p < NUM_PH; p++) begin
                    if (raddr == A_CAP_BASE + ADDR_W'(p))
                        rdata = caps[p*DW +: DW];
                end
            end
        endcase
    end

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_trip |=> flag);
    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ind_clr) |=> flag);
    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_clr && !any_trip) |=> !flag);
endmodule

// File: rtl/phase_overcurrent_monitor.sv
// Top of the per-phase overcurrent monitor. One compare/capture slice
// per phase plus a shared register file. Assumes RMS samples arrive
// already computed, each with a one-cycle valid strobe.
module phase_overcurrent_monitor
    import ocm_pkg::*;
#(
    parameter int NUM_PH = 3,
    parameter int DW     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PH*DW-1:0] cur_rms,
    input  logic [NUM_PH-1:0]    cur_vld,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_waddr,
    input  logic [DW-1:0]        reg_wdata,
    input  logic [ADDR_W-1:0]    reg_raddr,
    output logic [DW-1:0]        reg_rdata,
    output logic                 oc_irq
);
    logic [DW-1:0]        limit;
    logic [NUM_PH-1:0]    mask;
    logic [NUM_PH-1:0]    trip;
    logic [NUM_PH-1:0]    ind;
    logic [NUM_PH*DW-1:0] caps;
    logic                 ind_clr;
    logic                 flag;

    ocm_regs #(.NUM_PH(NUM_PH), .DW(DW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .waddr    (reg_waddr),
        .wdata    (reg_wdata),
        .raddr    (reg_raddr),
        .rdata    (reg_rdata),
        .any_trip (|trip),
        .ind      (ind),
        .caps     (caps),
        .limit    (limit),
        .mask     (mask),
        .ind_clr  (ind_clr),
        .flag     (flag)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        ocm_phase_slice #(.DW(DW)) slice_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_rms  (cur_rms[p*DW +: DW]),
            .in_vld  (cur_vld[p]),
            .mon_en  (mask[p]),
            .limit   (limit),
            .ind_clr (ind_clr),
            .trip    (trip[p]),
            .ind     (ind[p]),
            .cap     (caps[p*DW +: DW])
        );
    end

    // Interrupt follows the sticky flag.
    assign oc_irq = flag;

    // R7
    masked_no_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ind[0] && !mask[0]) |=> !ind[0]);
endmodule

// File: tb/phase_overcurrent_monitor_tb_top.sv
module phase_overcurrent_monitor_tb_top;
    localparam int NPH = 3;
    localparam int DW  = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPH*DW-1:0] cur_rms = '0;
    logic [NPH-1:0]    cur_vld = '0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_waddr = '0;
    logic [DW-1:0]     reg_wdata = '0;
    logic [2:0]        reg_raddr = '0;
    logic [DW-1:0]     reg_rdata;
    logic              oc_irq;

    int    errs = 0;
    int    checks = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_lim, m_mask, m_flag;
    int m_ind[NPH];
    int m_cap[NPH];

    always #2 clk = ~clk;

    phase_overcurrent_monitor #(.NUM_PH(NPH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_rms(cur_rms), .cur_vld(cur_vld),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .oc_irq(oc_irq)
    );

    // Reference model update on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lim = 32'h00FF_FFFF; m_mask = 0; m_flag = 0;
            for (int p = 0; p < NPH; p++) begin m_ind[p] = 0; m_cap[p] = 0; end
            chk_on = 1;
        end else begin
            int any_t;
            int clr;
            any_t = 0;
            clr = (reg_wr && reg_waddr == 3'd2 && reg_wdata[0]) ? 1 : 0;
            for (int p = 0; p < NPH; p++) begin
                int s;
                s = int'(cur_rms[p*DW +: DW]);
                if (cur_vld[p] && ((m_mask >> p) & 1) == 1 && s > m_lim) begin
                    any_t = 1;
                    if (m_ind[p] == 0 || s > m_cap[p]) m_cap[p] = s;
                    m_ind[p] = 1;
                end else if (clr == 1) begin
                    m_ind[p] = 0;
                end
            end
            if (any_t == 1) m_flag = 1;
            else if (clr == 1) m_flag = 0;
            if (reg_wr && reg_waddr == 3'd0) m_lim = int'(reg_wdata);
            if (reg_wr && reg_waddr == 3'd1) m_mask = int'(reg_wdata) & 7;
        end
    end

    function automatic int exp_rd(input int a);
        int v;
        v = 0;
        if (a == 0) v = m_lim;
        else if (a == 1) v = m_mask;
        else if (a == 2) begin
            v = m_flag;
            for (int p = 0; p < NPH; p++) v = v | (m_ind[p] << (4 + p));
        end else if (a >= 3 && a < 3 + NPH) v = m_cap[a-3];
        return v;
    endfunction

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (chk_on && rst_n && !done) begin
            checks++;
            if (int'(oc_irq) != m_flag) begin
                errs++;
                $display("FAIL %s: oc_irq got %0d exp %0d", cur_req, oc_irq, m_flag);
            end
            checks++;
            if (int'(reg_rdata) != exp_rd(int'(reg_raddr))) begin
                errs++;
                $display("FAIL %s: rdata[a=%0d] got %h exp %h", cur_req,
                         reg_raddr, reg_rdata, exp_rd(int'(reg_raddr)));
            end
        end
    end

    task automatic step(input logic [2:0] vld, input int s0, input int s1,
                        input int s2, input logic wr, input int wa,
                        input int wd, input int ra);
        @(negedge clk); #1;
        cur_vld = vld;
        cur_rms[0*DW +: DW] = DW'(s0);
        cur_rms[1*DW +: DW] = DW'(s1);
        cur_rms[2*DW +: DW] = DW'(s2);
        reg_wr = wr; reg_waddr = 3'(wa); reg_wdata = DW'(wd); reg_raddr = 3'(ra);
    endtask

    task automatic scan();
        for (int a = 0; a < 8; a++) step(3'b000, 0, 0, 0, 1'b0, 0, 0, a);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";  scan();
        cur_req = "R10"; // limit/mask access, upper mask bits dropped
        step(3'b000, 0, 0, 0, 1'b1, 0, 1000, 0);
        step(3'b000, 0, 0, 0, 1'b1, 1, 'hFF, 0);
        scan();
        cur_req = "R2";  // equal and invalid do not trip
        step(3'b001, 1000, 0, 0, 1'b0, 0, 0, 2);
        step(3'b000, 5000, 5000, 5000, 1'b0, 0, 0, 2);
        step(3'b000, 0, 0, 0, 1'b0, 0, 0, 3);
        cur_req = "R3";  // strict greater trips phase 0
        step(3'b001, 1001, 0, 0, 1'b0, 0, 0, 2);
        cur_req = "R4";  step(3'b000, 0, 0, 0, 1'b0, 0, 0, 2);
        cur_req = "R5";  step(3'b000, 0, 0, 0, 1'b0, 0, 0, 3);
        cur_req = "R3";  repeat (3) step(3'b000, 0, 0, 0, 1'b0, 0, 0, 2);
        cur_req = "R6";  // smaller ignored, larger kept
        step(3'b001, 1500, 0, 0, 1'b0, 0, 0, 3);
        step(3'b001, 1200, 0, 0, 1'b0, 0, 0, 3);
        step(3'b000, 0, 0, 0, 1'b0, 0, 0, 3);
        step(3'b010, 0, 3000, 0, 1'b0, 0, 0, 4);
        step(3'b010, 2000, 2000, 0, 1'b0, 0, 0, 4);
        scan();
        cur_req = "R8";  // write 0 no effect, then clear
        step(3'b000, 0, 0, 0, 1'b1, 2, 'hFE, 2);
        step(3'b000, 0, 0, 0, 1'b1, 2, 1, 2);
        step(3'b000, 0, 0, 0, 1'b0, 0, 0, 2);
        scan();
        cur_req = "R5";  // fresh indicator allows a smaller load
        step(3'b001, 1100, 0, 0, 1'b0, 0, 0, 3);
        step(3'b000, 0, 0, 0, 1'b0, 0, 0, 3);
        cur_req = "R9";  // clear and trip in one cycle
        step(3'b100, 0, 0, 4000, 1'b1, 2, 1, 2);
        step(3'b000, 0, 0, 0, 1'b0, 0, 0, 2);
        step(3'b000, 0, 0, 0, 1'b0, 0, 0, 5);
        cur_req = "R7";  // disable phase 2, drive it hard
        step(3'b000, 0, 0, 0, 1'b1, 2, 1, 2);
        step(3'b000, 0, 0, 0, 1'b1, 1, 3, 1);
        step(3'b100, 0, 0, 'hFFFFFF, 1'b0, 0, 0, 2);
        step(3'b100, 0, 0, 'hFFFFFF, 1'b0, 0, 0, 5);
        step(3'b000, 0, 0, 0, 1'b0, 0, 0, 2);
        scan();
        cur_req = "R2";  // raise limit, phase 1 at equal then above
        step(3'b000, 0, 0, 0, 1'b1, 0, 'h800000, 0);
        step(3'b010, 0, 'h800000, 0, 1'b0, 0, 0, 2);
        step(3'b010, 0, 'h800001, 0, 1'b0, 0, 0, 2);
        scan();
        cur_req = "R1";  // reset again
        @(negedge clk); #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        scan();
        finish_run();
    end
endmodule